// File: doc/BRIEF.md
# NAND Flash Write-Strobe Timing Generator

This block produces the command, address and data write cycles on an 8-bit NAND flash bus. A host presents a byte and a cycle kind for one clock cycle. When the block is idle and enabled, it accepts the request and raises the matching latch line: the command-latch line for a command byte, the address-latch line for an address byte, and neither line for a data byte. It then waits out a setup phase, drives the active-low write strobe low for a strobe phase, and keeps the byte on the bus through a hold phase. After that it returns to idle and gives a one-cycle done pulse.

Each of the three phase lengths comes from a configuration word that is programmed as the cycle count minus one. The setup field is narrow and the strobe and hold fields are wider. A two-bit control word holds an enable bit and an active-low chip-select bit. The configuration is copied when a request is accepted, so software can reprogram the timing for the next cycle while the current one is still running.

Top module: `nand_wr_strobe`

## Requirements
- R1: Coming out of reset, cfg_rdata_o reads all ones, ctl_rdata_o reads 2'b10 (enable 0, chip-select bit 1), ce_no and we_no are high, and busy_o and done_o are low.
- R2: A request is accepted only when ctl bit 0 (enable) is 1 and busy_o is low. A request made while enable is 0 leaves busy_o low and we_no high.
- R3: Kind 2'b00 (command) raises cle_o and kind 2'b01 (address) raises ale_o. Kinds 2'b10 and 2'b11 (data) raise neither line. The line stays high, and io_o holds the byte with io_oe_o high, for every busy cycle. At most one of cle_o and ale_o is high at any time.
- R4: The configuration word is {setup[SETUP_W-1:0], strobe[PHASE_W-1:0], hold[PHASE_W-1:0]}, with hold in the low bits. busy_o rises in the cycle after acceptance, and we_no stays high for setup+1 busy cycles before it falls.
- R5: we_no is low for exactly strobe+1 consecutive cycles, and only while busy_o is high.
- R6: After we_no rises, busy_o stays high for hold+1 more cycles, with the byte still driven.
- R7: In the cycle after the hold phase ends, busy_o is low and done_o is high for exactly one cycle. A request present in that cycle is accepted.
- R8: A request made while busy_o is high is ignored. It changes neither the byte nor the kind of the cycle in flight, and it adds no extra done pulse.
- R9: A configuration write during a cycle does not change that cycle's phase lengths. It applies from the next accepted request.
- R10: ce_no is low only when enable is 1 and ctl bit 1 is 0. Otherwise ce_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | CFG_W | Configuration word {setup, strobe, hold}, each field count minus one |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 2 | Bit 0 enable, bit 1 chip-select (active low) |
| cfg_rdata_o | output | CFG_W | Current configuration word |
| ctl_rdata_o | output | 2 | Current control word |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 2 | 00 command, 01 address, 10 or 11 data |
| req_byte_i | input | DATA_W | Byte to write |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle pulse at cycle end |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| ce_no | output | 1 | Chip enable, active low |
| io_o | output | DATA_W | Bus byte |
| io_oe_o | output | 1 | Bus drive enable |

## Verification
Two events can fall in the same cycle: the done pulse that ends one write and the acceptance of the next request. This happens because busy_o is already low in the done cycle. The bench provokes it by holding a new request, with a different byte and kind, across the whole of the previous write. The scoreboard then checks three things: the first write's byte and latch line never change, each write's setup, strobe and hold lengths match the configuration taken when that write was accepted, and the number of done pulses equals the number of queued requests.

// File: rtl/nand_wr_pkg.sv
package nand_wr_pkg;
  typedef enum logic [1:0] {
    KIND_CMD  = 2'b00,
    KIND_ADDR = 2'b01,
    KIND_DAT0 = 2'b10,
    KIND_DAT1 = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_SETUP  = 2'b01,
    PH_STROBE = 2'b10,
    PH_HOLD   = 2'b11
  } phase_e;
endpackage

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs #(
  parameter int SETUP_W = 2,
  parameter int PHASE_W = 3,
  parameter int CFG_W   = SETUP_W + 2*PHASE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             ctl_we_i,
  input  logic [1:0]       ctl_wdata_i,
  output logic [CFG_W-1:0] cfg_q_o,
  output logic             en_o,
  output logic             cs_n_o
);
  // reset to slowest timing, disabled, chip deselected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q_o <= '1;
      en_o    <= 1'b0;
      cs_n_o  <= 1'b1;
    end else begin
      if (cfg_we_i) cfg_q_o <= cfg_wdata_i;
      if (ctl_we_i) begin
        en_o   <= ctl_wdata_i[0];
        cs_n_o <= ctl_wdata_i[1];
      end
    end
  end
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_wr_pkg::*;
#(
  parameter int SETUP_W = 2,
  parameter int PHASE_W = 3,
  parameter int DATA_W  = 8,
  parameter int CFG_W   = SETUP_W + 2*PHASE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [DATA_W-1:0] req_byte_i,
  output phase_e            phase_o,
  output kind_e             kind_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W = (SETUP_W > PHASE_W) ? SETUP_W : PHASE_W;

  logic [SETUP_W-1:0] cfg_setup;
  logic [PHASE_W-1:0] cfg_strobe, cfg_hold;
  logic [PHASE_W-1:0] strobe_q, hold_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               accept;
  phase_e             phase_q;

  assign cfg_hold   = cfg_i[PHASE_W-1:0];
  assign cfg_strobe = cfg_i[2*PHASE_W-1:PHASE_W];
  assign cfg_setup  = cfg_i[CFG_W-1:2*PHASE_W];
  assign accept     = req_valid_i && en_i && (phase_q == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
      kind_o   <= KIND_CMD;
      byte_o   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q  <= PH_SETUP;
          cnt_q    <= CNT_W'(cfg_setup);
          strobe_q <= cfg_strobe;
          hold_q   <= cfg_hold;
          kind_o   <= kind_e'(req_kind_i);
          byte_o   <= req_byte_i;
        end
        PH_SETUP: if (cnt_q == '0) begin
          phase_q <= PH_STROBE;
          cnt_q   <= CNT_W'(strobe_q);
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (cnt_q == '0) begin
          phase_q <= PH_HOLD;
          cnt_q   <= CNT_W'(hold_q);
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_q == '0) begin
          phase_q <= PH_IDLE;
          done_o  <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign busy_o  = (phase_q != PH_IDLE);

  assert_accept_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(en_i) && $past(req_valid_i)));
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_on_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_byte_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(byte_o) && $stable(kind_o)));
  assert_phase_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && $past(phase_q) != PH_HOLD) |-> ($past(phase_q) == PH_STROBE));
endmodule

// File: rtl/nand_pin_drv.sv
module nand_pin_drv
  import nand_wr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  phase_e            phase_i,
  input  kind_e             kind_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              en_i,
  input  logic              cs_n_i,
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              ce_no,
  output logic [DATA_W-1:0] io_o,
  output logic              io_oe_o
);
  localparam int N_LATCH = 2;
  logic              active;
  logic [N_LATCH-1:0] latch;

  assign active = (phase_i != PH_IDLE);

  // one latch line per non-data kind, indexed by kind code
  for (genvar g = 0; g < N_LATCH; g++) begin : g_latch
    assign latch[g] = active && (kind_i == kind_e'(g));
  end

  assign cle_o   = latch[0];
  assign ale_o   = latch[1];
  assign we_no   = (phase_i != PH_STROBE);
  assign ce_no   = cs_n_i || !en_i;
  assign io_o    = active ? byte_i : '0;
  assign io_oe_o = active;

  assert_one_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  assert_strobe_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> io_oe_o);
endmodule

// File: rtl/nand_wr_strobe.sv
module nand_wr_strobe
  import nand_wr_pkg::*;
#(
  parameter int SETUP_W = 2,
  parameter int PHASE_W = 3,
  parameter int DATA_W  = 8,
  localparam int CFG_W  = SETUP_W + 2*PHASE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              ctl_we_i,
  input  logic [1:0]        ctl_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  output logic [1:0]        ctl_rdata_o,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [DATA_W-1:0] req_byte_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              ce_no,
  output logic [DATA_W-1:0] io_o,
  output logic              io_oe_o
);
  logic              en, cs_n;
  logic [CFG_W-1:0]  cfg_q;
  phase_e            phase;
  kind_e             kind;
  logic [DATA_W-1:0] byte_q;

  nand_cfg_regs #(.SETUP_W(SETUP_W), .PHASE_W(PHASE_W), .CFG_W(CFG_W)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .ctl_we_i, .ctl_wdata_i,
    .cfg_q_o(cfg_q), .en_o(en), .cs_n_o(cs_n)
  );

  nand_phase_seq #(.SETUP_W(SETUP_W), .PHASE_W(PHASE_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_seq (
    .clk_i, .rst_ni, .en_i(en), .cfg_i(cfg_q), .req_valid_i, .req_kind_i, .req_byte_i,
    .phase_o(phase), .kind_o(kind), .byte_o(byte_q), .busy_o, .done_o
  );

  nand_pin_drv #(.DATA_W(DATA_W)) u_pins (
    .phase_i(phase), .kind_i(kind), .byte_i(byte_q), .en_i(en), .cs_n_i(cs_n),
    .clk_i, .rst_ni, .cle_o, .ale_o, .we_no, .ce_no, .io_o, .io_oe_o
  );

  assign cfg_rdata_o = cfg_q;
  assign ctl_rdata_o = {cs_n, en};
endmodule

// File: tb/nand_wr_strobe_bench.sv
`timescale 1ns/1ps
module nand_wr_strobe_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, ctl_we = 1'b0, req_valid = 1'b0;
  logic [7:0] cfg_wdata = '0, req_byte = '0;
  logic [1:0] ctl_wdata = '0, req_kind = '0;
  logic [7:0] cfg_rdata, io;
  logic [1:0] ctl_rdata;
  logic       busy, done, cle, ale, we_n, ce_n, io_oe;

  always #2 clk = ~clk;

  nand_wr_strobe u_nand_wr_strobe (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .cfg_rdata_o(cfg_rdata),
    .ctl_rdata_o(ctl_rdata), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_byte_i(req_byte), .busy_o(busy), .done_o(done), .cle_o(cle), .ale_o(ale),
    .we_no(we_n), .ce_no(ce_n), .io_o(io), .io_oe_o(io_oe)
  );

  typedef struct { logic [1:0] kind; logic [7:0] b; int s, w, h; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [7:0] cfg_model = 8'hFF;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wcfg(logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    cfg_model = v;
  endtask

  task automatic wctl(logic [1:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  // driver: holds the request until a negedge sees the block idle
  task automatic send(logic [1:0] k, logic [7:0] b);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_byte = b;
    while (busy) @(negedge clk);
    e.kind = k; e.b = b;
    e.s = cfg_model[7:6] + 1; e.w = cfg_model[5:3] + 1; e.h = cfg_model[2:0] + 1;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    int s = 0, w = 0, h = 0;
    bit low_seen = 0, consist = 1, prev_done = 0;
    logic rc = 0, ra = 0;
    logic [7:0] rio = '0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy) begin
          if (s + w + h == 0) begin rc = cle; ra = ale; rio = io; end
          else if (cle !== rc || ale !== ra || io !== rio) consist = 0;
          if (!io_oe || (cle && ale)) consist = 0;
          if (we_n && !low_seen) s++;
          else if (!we_n) begin
            w++; low_seen = 1;
            if (h != 0) consist = 0;
          end
          else h++;
        end else if (!we_n) consist = 0;
        if (done) begin
          chk(!busy, "R7", "busy low in done cycle", busy, 0);
          chk(!prev_done, "R7", "done one cycle wide", prev_done, 0);
          if (q.size() == 0) chk(0, "R8", "unexpected done pulse", 1, 0);
          else begin
            e = q.pop_front();
            chk(rc == (e.kind == 2'b00) && ra == (e.kind == 2'b01), "R3", "latch lines {cle,ale}",
                {rc, ra}, {e.kind == 2'b00, e.kind == 2'b01});
            chk(rio == e.b, "R8", "byte of cycle", rio, e.b);
            chk(consist, "R3", "lines and bus stable while busy", consist, 1);
            chk(s == e.s, "R4", "setup cycles", s, e.s);
            chk(w == e.w, "R5", "strobe cycles", w, e.w);
            chk(h == e.h, "R6", "hold cycles", h, e.h);
          end
          s = 0; w = 0; h = 0; low_seen = 0; consist = 1;
        end
        prev_done = done;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "WDOG", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 8'hFF, "R1", "cfg reset", cfg_rdata, 8'hFF);
    chk(ctl_rdata == 2'b10, "R1", "ctl reset", ctl_rdata, 2'b10);
    chk(ce_n && we_n && !busy && !done, "R1", "pins reset {ce,we,busy,done}",
        {ce_n, we_n, busy, done}, 4'b1100);
    rst_n = 1'b1;
    // R2 request while disabled
    @(negedge clk); req_valid = 1'b1; req_kind = 2'b00; req_byte = 8'h11;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy && we_n, "R2", "disabled request ignored {busy,we}", {busy, we_n}, 2'b01);
    end
    req_valid = 1'b0;
    // R10 chip select only with enable
    wctl(2'b00);
    chk(ce_n, "R10", "ce with enable 0", ce_n, 1);
    wctl(2'b11);
    chk(ce_n && ctl_rdata == 2'b11, "R10", "ce deselected when enabled", ce_n, 1);
    wctl(2'b01);
    chk(!ce_n, "R10", "ce asserted", ce_n, 0);
    // R4-R6 default timing, R9 reprogram mid-cycle
    send(2'b00, 8'h70);
    wcfg(8'b00_001_010);
    chk(cfg_rdata == 8'b00_001_010, "R9", "cfg readback", cfg_rdata, 8'b00_001_010);
    send(2'b01, 8'h12);
    // R7 and R8: back-to-back requests held across busy
    send(2'b10, 8'hA5);
    send(2'b11, 8'h3C);
    send(2'b00, 8'hFF);
    wcfg(8'b01_000_111);
    send(2'b01, 8'h00);
    wcfg(8'h00);
    send(2'b00, 8'h5A);
    send(2'b10, 8'hC3);
    for (int i = 0; i < 200 && (q.size() != 0 || busy); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R8", "all queued cycles completed", q.size(), 0);
    chk(!busy && we_n, "R7", "idle at end", busy, 0);
    finished = 1;
    summary();
  end
endmodule